// File: doc/BRIEF.md
# Converter Serial Readout Port with Chain Pass-Through

This block is the device-side serial port of a successive-approximation converter. It takes a conversion-done strobe and a result word from the conversion core and presents the word on a serial output under the control of three host-driven pins: a convert line, a serial data input and a serial clock. There is no configuration register. The working mode and the optional start bit are chosen from pin levels at two moments: the rising edge of the convert line, and the cycle in which the core reports that the conversion has ended.

In select mode the port behaves like an SPI peripheral. The output is released while a conversion runs. It is driven once the convert line or the data input goes low, and it is released again after the last bit or when both lines return high. In chain mode the port is one link of a long shift register. The output is always driven, and the data input is shifted in behind the result, so several devices share one data line. All pins are sampled by a faster system clock through two-flop synchronisers. Output drive is an explicit enable flag rather than a tri-state pad.

Top module: `adc_readout_port`

## Requirements
- R1: After reset the output enable `dout_en` is low.
- R2: On a rising edge of `conv_i`, the `din_i` level one sample before the edge picks the mode: high selects select mode and releases the output, low selects chain mode. With `din_i` and `conv_i` tied together, chain mode results.
- R3: In select mode without a start bit, driving `conv_i` low after the result is ready drives the result MSB on `dout`.
- R4: In select mode with `conv_i` held high, driving `din_i` low after the result is ready drives the result MSB.
- R5: In select mode, if `conv_i` or `din_i` is low when the done strobe arrives, the output is driven low at once as a start bit ahead of the data.
- R6: Data leaves MSB first, and each falling edge of `sclk_i` moves the output to the next bit. A start bit is consumed by the first falling edge.
- R7: In select mode the output is released on the W-th falling edge of `sclk_i`, or on the (W+1)-th when a start bit was sent.
- R8: In select mode, raising both `conv_i` and `din_i` after the frame has begun releases the output, and it stays released until the next conversion.
- R9: In chain mode, an `sclk_i` level high one sample before the `conv_i` rising edge enables the start bit, and low disables it.
- R10: In chain mode the output is driven at all times. It is low until the result is ready, and without a start bit it then shows the result MSB.
- R11: In chain mode each falling edge of `sclk_i` shifts `din_i` in behind the result, so the `din_i` level sampled at falling edge k appears on `dout` after falling edge k+W-1.
- R12: In chain mode with a start bit, `dout` stays low until the result is ready and `din_i` has been seen high. It then goes high, and the first falling edge replaces the start bit with the MSB.
- R13: A done strobe that arrives while a frame is partly read does not disturb that frame. Its word is loaded when the frame ends.
- R14: Falling edges of `sclk_i` before the result is ready shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert line from the host (asynchronous) |
| din_i | input | 1 | Serial data / mode-select input (asynchronous) |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| done_i | input | 1 | One-cycle strobe from the core: conversion finished |
| result_i | input | W | Conversion result, valid with `done_i` |
| dout | output | 1 | Serial data output value |
| dout_en | output | 1 | Output drive enable; low means high impedance |

## Verification
The bench builds the port at its default word width of 14 and synchroniser depth of 2. At this size the full frame in both modes can be read and checked bit by bit. That covers the release on the 14th and on the 15th falling edge, and the step in chain mode where the result has been shifted out and `din_i` values begin to reach the output. With the default depth, one host step settles well inside the few cycles the bench waits, so each pin change can be checked against a single expected value.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  typedef enum logic {
    MODE_SEL   = 1'b0,
    MODE_CHAIN = 1'b1
  } port_mode_t;

  // Number of falling clock edges in one frame.
  function automatic int unsigned frame_bits(int unsigned width, logic with_start);
    return width + (with_start ? 1 : 0);
  endfunction

  // Mode picked from the data-input level seen just before the convert edge.
  function automatic port_mode_t mode_from_level(logic din_level);
    return din_level ? MODE_SEL : MODE_CHAIN;
  endfunction

endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int N     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] lvl_d_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [DEPTH-1:0] stage;
    logic             prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage <= '0;
        prev  <= 1'b0;
      end else begin
        stage <= {stage[DEPTH-2:0], pin_i[b]};
        prev  <= stage[DEPTH-1];
      end
    end

    assign lvl_o[b]   = stage[DEPTH-1];
    assign lvl_d_o[b] = prev;
  end

endmodule

// File: rtl/adcsp_shreg.sv
module adcsp_shreg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         ld_now_i,
  input  logic         ld_pend_i,
  input  logic         pend_cap_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic         msb_o
);

  logic [W-1:0] sreg;
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      held <= '0;
    end else begin
      if (pend_cap_i) held <= word_i;
      if (ld_now_i)       sreg <= word_i;
      else if (ld_pend_i) sreg <= held;
      else if (shift_i)   sreg <= {sreg[W-2:0], ser_i};
    end
  end

  assign msb_o = sreg[W-1];

endmodule

// File: rtl/adcsp_ctrl.sv
module adcsp_ctrl
  import adcsp_pkg::*;
#(
  parameter int W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_s,
  input  logic       din_s,
  input  logic       din_d,
  input  logic       sclk_d,
  input  logic       conv_rise,
  input  logic       sclk_fall,
  input  logic       done_i,
  output port_mode_t mode_o,
  output logic       rdy_o,
  output logic       start_o,
  output logic       fin_o,
  output logic       busy_o,
  output logic       din_hi_o,
  output logic       chain_on_o,
  output logic       en_low_o,
  output logic       ld_now_o,
  output logic       ld_pend_o,
  output logic       pend_cap_o,
  output logic       shift_o
);

  localparam int CW = $clog2(W + 2);

  port_mode_t    mode;
  logic          busy_q, conv_q, rdy_q, start_q, din_hi, fin_q, pend_v, chain_on;
  logic [CW-1:0] cnt;
  logic [CW-1:0] flen;
  logic          en_low, frame_act, fall_ok, last_fall, release_sel, frame_end;
  logic          nxt_busy, din_hi_set;

  assign flen      = CW'(frame_bits(W, busy_q));
  assign en_low    = !(conv_s && din_s);
  assign frame_act = rdy_q && !fin_q && (cnt != '0) && (cnt != flen);

  always_comb begin
    if (mode == MODE_SEL) fall_ok = sclk_fall && rdy_q && !fin_q && en_low;
    else                  fall_ok = sclk_fall && rdy_q && (!busy_q || din_hi);
  end

  assign last_fall   = fall_ok && (cnt == flen - CW'(1));
  assign release_sel = (mode == MODE_SEL) && rdy_q && !fin_q && (cnt != '0) && !en_low;
  assign frame_end   = last_fall || release_sel;

  assign ld_now_o   = done_i && (!frame_act || frame_end);
  assign pend_cap_o = done_i && frame_act && !frame_end;
  assign ld_pend_o  = frame_end && pend_v && !done_i;
  assign shift_o    = fall_ok && !start_q;

  assign nxt_busy   = (mode == MODE_SEL && ld_now_o) ? en_low : busy_q;
  assign din_hi_set = (mode == MODE_CHAIN) && rdy_q && din_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_SEL;
      busy_q   <= 1'b0;
      conv_q   <= 1'b0;
      rdy_q    <= 1'b0;
      start_q  <= 1'b0;
      din_hi   <= 1'b0;
      fin_q    <= 1'b0;
      pend_v   <= 1'b0;
      chain_on <= 1'b0;
      cnt      <= '0;
    end else begin
      if (din_hi_set) din_hi <= 1'b1;
      if (fall_ok) begin
        if (start_q) start_q <= 1'b0;
        if (cnt != flen) cnt <= cnt + CW'(1);
        if (mode == MODE_SEL && last_fall) fin_q <= 1'b1;
      end
      if (release_sel) fin_q <= 1'b1;
      if (pend_cap_o) pend_v <= 1'b1;
      if (ld_now_o || ld_pend_o) begin
        rdy_q   <= 1'b1;
        cnt     <= '0;
        fin_q   <= 1'b0;
        busy_q  <= nxt_busy;
        start_q <= nxt_busy;
      end
      if (ld_pend_o) pend_v <= 1'b0;
      if (ld_now_o)  conv_q <= 1'b0;
      if (conv_rise) begin
        mode     <= mode_from_level(din_d);
        busy_q   <= !din_d && sclk_d;
        chain_on <= !din_d;
        conv_q   <= 1'b1;
        rdy_q    <= 1'b0;
        start_q  <= 1'b0;
        din_hi   <= 1'b0;
        fin_q    <= 1'b0;
        cnt      <= '0;
      end
    end
  end

  assign mode_o     = mode;
  assign rdy_o      = rdy_q;
  assign start_o    = start_q;
  assign fin_o      = fin_q;
  assign busy_o     = busy_q;
  assign din_hi_o   = din_hi;
  assign chain_on_o = chain_on;
  assign en_low_o   = en_low;

  // R6: an accepted falling edge advances the bit counter by exactly one
  assert_one_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ok && !conv_rise && !ld_now_o && !ld_pend_o && cnt < flen) |=> cnt == $past(cnt) + CW'(1));

  // R14: no counting while the conversion runs
  assert_idle_conv_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_q && !rdy_q) |-> !fall_ok);

  // R13: a held word is never lost while it waits
  assert_pend_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !ld_pend_o) |=> pend_v);

endmodule

// File: rtl/adc_readout_port.sv
module adc_readout_port
  import adcsp_pkg::*;
#(
  parameter int W     = 14,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_i,
  input  logic         din_i,
  input  logic         sclk_i,
  input  logic         done_i,
  input  logic [W-1:0] result_i,
  output logic         dout,
  output logic         dout_en
);

  logic [2:0] lvl, lvl_d;
  logic       conv_s, din_s, sclk_s, conv_d, din_d, sclk_d;
  logic       conv_rise, sclk_fall;

  port_mode_t mode;
  logic       rdy, start, fin, busy, din_hi, chain_on, en_low;
  logic       ld_now, ld_pend, pend_cap, shift, msb;

  adcsp_sync #(.N(3), .DEPTH(DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({sclk_i, din_i, conv_i}),
    .lvl_o  (lvl),
    .lvl_d_o(lvl_d)
  );

  assign {sclk_s, din_s, conv_s} = lvl;
  assign {sclk_d, din_d, conv_d} = lvl_d;
  assign conv_rise = conv_s && !conv_d;
  assign sclk_fall = !sclk_s && sclk_d;

  adcsp_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_s    (conv_s),
    .din_s     (din_s),
    .din_d     (din_d),
    .sclk_d    (sclk_d),
    .conv_rise (conv_rise),
    .sclk_fall (sclk_fall),
    .done_i    (done_i),
    .mode_o    (mode),
    .rdy_o     (rdy),
    .start_o   (start),
    .fin_o     (fin),
    .busy_o    (busy),
    .din_hi_o  (din_hi),
    .chain_on_o(chain_on),
    .en_low_o  (en_low),
    .ld_now_o  (ld_now),
    .ld_pend_o (ld_pend),
    .pend_cap_o(pend_cap),
    .shift_o   (shift)
  );

  adcsp_shreg #(.W(W)) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_i    (result_i),
    .ld_now_i  (ld_now),
    .ld_pend_i (ld_pend),
    .pend_cap_i(pend_cap),
    .shift_i   (shift),
    .ser_i     (din_s),
    .msb_o     (msb)
  );

  always_comb begin
    if (mode == MODE_SEL) begin
      dout_en = rdy && !fin && en_low;
      dout    = start ? 1'b0 : msb;
    end else begin
      dout_en = chain_on;
      if (!rdy)                dout = 1'b0;
      else if (!busy)          dout = msb;
      else if (!din_hi)        dout = 1'b0;
      else                     dout = start ? 1'b1 : msb;
    end
  end

  // R1: released output straight after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !dout_en);

  // R2: select mode keeps the line released until a result exists
  assert_sel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SEL && !rdy) |-> !dout_en);

  // R10: chain mode drives low before the result is ready
  assert_chain_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CHAIN && chain_on && !rdy) |-> (dout_en && !dout));

  // R5: a start bit in select mode is driven low
  assert_sel_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SEL && start && dout_en) |-> !dout);

  // R12: chain start bit never high before the upstream input has gone high
  assert_chain_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CHAIN && busy && !din_hi) |-> !dout);

endmodule

// File: tb/sim_adc_readout_port.sv
module sim_adc_readout_port;

  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_i = 1'b0, din_i = 1'b0, sclk_i = 1'b0, done_i = 1'b0;
  logic [W-1:0] result_i = '0;
  logic         dout, dout_en;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  adc_readout_port #(.W(W), .DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .din_i(din_i), .sclk_i(sclk_i),
    .done_i(done_i), .result_i(result_i), .dout(dout), .dout_en(dout_en)
  );

  typedef struct {
    logic  en;
    logic  val;
    bit    chk_val;
    string tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;

  // monitor: pops expected items and compares at a falling clock edge
  initial begin
    forever begin
      @(chk_ev);
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        total++;
        if (dout_en !== it.en || (it.chk_val && dout !== it.val)) begin
          bad++;
          $display("FAIL %s: got en=%b val=%b, want en=%b val=%b",
                   it.tag, dout_en, dout, it.en, it.val);
        end
      end
    end
  end

  task automatic settle();
    repeat (8) @(posedge clk);
  endtask

  task automatic expect_out(input logic en, input logic val, input bit cv, input string tag);
    exp_t it;
    it.en = en; it.val = val; it.chk_val = cv; it.tag = tag;
    q.push_back(it);
    -> chk_ev;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fall_once(input logic d);
    din_i = d;  settle();
    sclk_i = 1'b1; settle();
    sclk_i = 1'b0; settle();
  endtask

  task automatic sel_fall();
    sclk_i = 1'b1; settle();
    sclk_i = 1'b0; settle();
  endtask

  task automatic strobe_done(input logic [W-1:0] w);
    @(negedge clk);
    result_i = w;
    done_i   = 1'b1;
    @(negedge clk);
    done_i   = 1'b0;
    settle();
  endtask

  task automatic new_conv(input logic d, input logic s);
    conv_i = 1'b0; settle();
    din_i = d; sclk_i = s; settle();
    conv_i = 1'b1; settle();
  endtask

  initial begin
    logic [W-1:0] w1, w2;
    logic [19:0]  pat;

    repeat (3) @(posedge clk);
    expect_out(1'b0, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    settle();
    expect_out(1'b0, 1'b0, 1'b0, "R1 after reset");

    // select mode, 3-wire, no start bit
    w1 = 14'h2A5C;
    new_conv(1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, "R2 select mode released");
    sel_fall();
    strobe_done(w1);
    expect_out(1'b0, 1'b0, 1'b0, "R3 no drive while conv high");
    conv_i = 1'b0; settle();
    expect_out(1'b1, w1[W-1], 1'b1, "R3 msb on conv low");
    for (int j = 1; j < W; j++) begin
      sel_fall();
      expect_out(1'b1, w1[W-1-j], 1'b1, "R6 select bit");
    end
    sel_fall();
    expect_out(1'b0, 1'b0, 1'b0, "R7 release after W edges");

    // select mode, 4-wire, early release
    w1 = 14'h1B36;
    new_conv(1'b1, 1'b0);
    strobe_done(w1);
    din_i = 1'b0; settle();
    expect_out(1'b1, w1[W-1], 1'b1, "R4 msb on din low");
    for (int j = 1; j <= 3; j++) begin
      sel_fall();
      expect_out(1'b1, w1[W-1-j], 1'b1, "R6 four-wire bit");
    end
    din_i = 1'b1; settle();
    expect_out(1'b0, 1'b0, 1'b0, "R8 release on din high");
    din_i = 1'b0; settle();
    expect_out(1'b0, 1'b0, 1'b0, "R8 stays released");

    // select mode with start bit
    w1 = 14'h3C91;
    new_conv(1'b1, 1'b0);
    conv_i = 1'b0; settle();
    expect_out(1'b0, 1'b0, 1'b0, "R2 released in conversion");
    sel_fall();
    strobe_done(w1);
    expect_out(1'b1, 1'b0, 1'b1, "R5 start bit low");
    for (int j = 0; j < W; j++) begin
      sel_fall();
      expect_out(1'b1, w1[W-1-j], 1'b1, "R14 R6 bit after start");
    end
    sel_fall();
    expect_out(1'b0, 1'b0, 1'b0, "R7 release after W+1 edges");

    // tied convert and data input picks chain mode
    conv_i = 1'b0; din_i = 1'b0; sclk_i = 1'b0; settle();
    conv_i = 1'b1; din_i = 1'b1; settle();
    expect_out(1'b1, 1'b0, 1'b1, "R2 tied gives chain");

    // chain mode, no start bit, pass-through
    w1  = 14'h25A7;
    pat = 20'hB3C5A;
    new_conv(1'b0, 1'b0);
    expect_out(1'b1, 1'b0, 1'b1, "R10 chain low before done");
    fall_once(1'b1);
    expect_out(1'b1, 1'b0, 1'b1, "R14 chain no shift before done");
    strobe_done(w1);
    expect_out(1'b1, w1[W-1], 1'b1, "R10 chain msb");
    for (int j = 1; j <= W + 5; j++) begin
      logic e;
      fall_once(pat[j-1]);
      e = (j < W) ? w1[W-1-j] : pat[j-W];
      expect_out(1'b1, e, 1'b1, (j < W) ? "R6 chain bit" : "R11 chain pass-through");
    end

    // chain mode, word arriving mid-frame is held
    w1 = 14'h0F3D;
    w2 = 14'h2C4B;
    new_conv(1'b0, 1'b0);
    strobe_done(w1);
    for (int j = 1; j <= 5; j++) fall_once(1'b0);
    strobe_done(w2);
    expect_out(1'b1, w1[W-6], 1'b1, "R13 frame undisturbed");
    for (int j = 6; j <= W; j++) fall_once(1'b0);
    expect_out(1'b1, w2[W-1], 1'b1, "R13 held word loaded");
    fall_once(1'b0);
    expect_out(1'b1, w2[W-2], 1'b1, "R13 held word shifts");

    // chain mode with start bit
    w1 = 14'h3A65;
    new_conv(1'b0, 1'b1);
    sclk_i = 1'b0; settle();
    expect_out(1'b1, 1'b0, 1'b1, "R9 chain start enabled, low");
    strobe_done(w1);
    expect_out(1'b1, 1'b0, 1'b1, "R12 low until din high");
    din_i = 1'b1; settle();
    expect_out(1'b1, 1'b1, 1'b1, "R12 start bit high");
    sel_fall();
    expect_out(1'b1, w1[W-1], 1'b1, "R12 msb after start");
    sel_fall();
    expect_out(1'b1, w1[W-2], 1'b1, "R6 next bit");

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got running, want finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule